// File: doc/BRIEF.md
# Byte-Lane Latched Bus Transceiver

This block sits between two 16-bit buses, A and B, and carries data across in both directions through two separate storage paths. One path holds data taken from A and presents it to B; the other holds data taken from B and presents it to A. Each path can pass data straight through, or it can freeze a value and hand it over later. Real-time and stored transfers therefore run in either direction without interfering.

The buses are split into byte lanes. Each lane has six active-low controls of its own: an enable, a capture gate and a drive enable for each direction. Wiring the same control of every lane together gives plain full-width operation. The storage elements are level-sensitive latches.

Each bus side is presented as a data vector plus one drive flag per lane, so the surrounding logic can build the tri-state buffers. The latch contents are brought out for observation. A per-lane flag reports when both directions of a lane are open and driving at the same time, which would close a loop through external pads.

Top module: `byte_latch_xcvr`

## Requirements
- R1: While a lane's A-to-B enable and A-to-B capture gate are both low, that lane's A-to-B store follows the A input byte (seen on `a2b_held_o`).
- R2: While a lane's A-to-B enable is high, its A-to-B store keeps its value whatever the capture gate and the A inputs do.
- R3: With the enable low, raising the capture gate freezes the store, and later changes on A do not reach it.
- R4: A lane of `b_o` carries that lane's A-to-B store, and its `b_drv_o` bit is 1, exactly when the lane's A-to-B enable and A-to-B drive enable are both low.
- R5: A lane that is not driven reads all zeros on its data output (`b_o` or `a_o`), with its drive bit at 0.
- R6: The data path does not invert: a driven bit equals the stored bit.
- R7: The B-to-A direction follows R1 to R4 with its own three controls, storing from `b_i` and driving `a_o`/`a_drv_o`.
- R8: Lane 0 is bits 7:0 and lane 1 is bits 15:8. Control bit n of each control vector acts on lane n only, and no lane's controls change another lane's store or outputs.
- R9: With matching controls tied across lanes, the block acts as one 16-bit transceiver.
- R10: `loop_flag_o[n]` is 1 exactly when all six controls of lane n are low. In that case both directions of the lane are transparent and driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | Data arriving from bus A |
| b_i | input | 16 | Data arriving from bus B |
| a2b_cen_i | input | 2 | A-to-B enable per lane, active low |
| a2b_len_i | input | 2 | A-to-B capture gate per lane, active low (low = transparent) |
| a2b_oen_i | input | 2 | A-to-B drive enable per lane, active low |
| b2a_cen_i | input | 2 | B-to-A enable per lane, active low |
| b2a_len_i | input | 2 | B-to-A capture gate per lane, active low |
| b2a_oen_i | input | 2 | B-to-A drive enable per lane, active low |
| b_o | output | 16 | Data toward bus B, zero in undriven lanes |
| b_drv_o | output | 2 | Per-lane drive flag for bus B |
| a_o | output | 16 | Data toward bus A, zero in undriven lanes |
| a_drv_o | output | 2 | Per-lane drive flag for bus A |
| a2b_held_o | output | 16 | Contents of the A-to-B stores |
| b2a_held_o | output | 16 | Contents of the B-to-A stores |
| loop_flag_o | output | 2 | Per-lane flag: both directions open and driving |

## Verification
The hardest case to reach is the one where the enable guards the store by itself. The capture gate is low, the enable is high, and new data is on the input. The lane then has to reopen for driving without ever passing through a state where both controls are low. The stimulus gets there in steps. It changes the gate and the data only while the enable is high, closes the gate again, and only then lowers the enable with the drive enable. Each control edge and each data change goes in a separate cycle, so no capture depends on which input settles first. The lane tests hold the other lane's controls in the opposite state, and the bench checks that the other lane's store and outputs stay the same.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned LANE_CNT  = 2;

  // one direction's active-low control set for a single lane
  typedef struct packed {
    logic cen;
    logic len;
    logic oen;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         cen_i,
  input  logic         len_i,
  output logic [W-1:0] q_o
);
  logic open_w;

  assign open_w = ~cen_i & ~len_i;

  // level-sensitive store: follows d_i while open, holds otherwise
  always_latch begin
    if (open_w) q_o = d_i;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] q_i,
  input  logic         cen_i,
  input  logic         oen_i,
  output logic [W-1:0] data_o,
  output logic         en_o
);
  always_comb begin
    en_o   = ~cen_i & ~oen_i;
    data_o = en_o ? q_i : '0;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int unsigned W = LANE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  dir_ctl_t     a2b_ctl_i,
  input  dir_ctl_t     b2a_ctl_i,
  output logic [W-1:0] b_o,
  output logic         b_drv_o,
  output logic [W-1:0] a_o,
  output logic         a_drv_o,
  output logic [W-1:0] a2b_q_o,
  output logic [W-1:0] b2a_q_o,
  output logic         loop_o
);
  xcvr_store #(.W(W)) a2b_store_i (
    .d_i   (a_i),
    .cen_i (a2b_ctl_i.cen),
    .len_i (a2b_ctl_i.len),
    .q_o   (a2b_q_o)
  );

  xcvr_store #(.W(W)) b2a_store_i (
    .d_i   (b_i),
    .cen_i (b2a_ctl_i.cen),
    .len_i (b2a_ctl_i.len),
    .q_o   (b2a_q_o)
  );

  xcvr_drive #(.W(W)) b_side_i (
    .q_i    (a2b_q_o),
    .cen_i  (a2b_ctl_i.cen),
    .oen_i  (a2b_ctl_i.oen),
    .data_o (b_o),
    .en_o   (b_drv_o)
  );

  xcvr_drive #(.W(W)) a_side_i (
    .q_i    (b2a_q_o),
    .cen_i  (b2a_ctl_i.cen),
    .oen_i  (b2a_ctl_i.oen),
    .data_o (a_o),
    .en_o   (a_drv_o)
  );

  // both directions transparent and driving: a loop through the pads
  assign loop_o = ~(|a2b_ctl_i) & ~(|b2a_ctl_i);
endmodule

// File: rtl/byte_latch_xcvr.sv
module byte_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned LANES  = LANE_CNT,
  parameter int unsigned BYTE_W = LANE_W,
  localparam int unsigned BUS_W = LANES * BYTE_W
) (
  input  logic [BUS_W-1:0] a_i,
  input  logic [BUS_W-1:0] b_i,
  input  logic [LANES-1:0] a2b_cen_i,
  input  logic [LANES-1:0] a2b_len_i,
  input  logic [LANES-1:0] a2b_oen_i,
  input  logic [LANES-1:0] b2a_cen_i,
  input  logic [LANES-1:0] b2a_len_i,
  input  logic [LANES-1:0] b2a_oen_i,
  output logic [BUS_W-1:0] b_o,
  output logic [LANES-1:0] b_drv_o,
  output logic [BUS_W-1:0] a_o,
  output logic [LANES-1:0] a_drv_o,
  output logic [BUS_W-1:0] a2b_held_o,
  output logic [BUS_W-1:0] b2a_held_o,
  output logic [LANES-1:0] loop_flag_o
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    localparam int unsigned LO = n * BYTE_W;
    dir_ctl_t a2b_ctl;
    dir_ctl_t b2a_ctl;

    assign a2b_ctl = '{cen: a2b_cen_i[n], len: a2b_len_i[n], oen: a2b_oen_i[n]};
    assign b2a_ctl = '{cen: b2a_cen_i[n], len: b2a_len_i[n], oen: b2a_oen_i[n]};

    xcvr_lane #(.W(BYTE_W)) lane_i (
      .a_i       (a_i[LO +: BYTE_W]),
      .b_i       (b_i[LO +: BYTE_W]),
      .a2b_ctl_i (a2b_ctl),
      .b2a_ctl_i (b2a_ctl),
      .b_o       (b_o[LO +: BYTE_W]),
      .b_drv_o   (b_drv_o[n]),
      .a_o       (a_o[LO +: BYTE_W]),
      .a_drv_o   (a_drv_o[n]),
      .a2b_q_o   (a2b_held_o[LO +: BYTE_W]),
      .b2a_q_o   (b2a_held_o[LO +: BYTE_W]),
      .loop_o    (loop_flag_o[n])
    );
  end
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned BUS_W = LANES * BYTE_W
) (
  input logic [BUS_W-1:0] a_i,
  input logic [BUS_W-1:0] b_i,
  input logic [LANES-1:0] a2b_cen_i,
  input logic [LANES-1:0] a2b_len_i,
  input logic [LANES-1:0] b2a_cen_i,
  input logic [LANES-1:0] b2a_len_i,
  input logic [BUS_W-1:0] b_o,
  input logic [LANES-1:0] b_drv_o,
  input logic [BUS_W-1:0] a_o,
  input logic [LANES-1:0] a_drv_o,
  input logic [BUS_W-1:0] a2b_held_o,
  input logic [BUS_W-1:0] b2a_held_o,
  input logic [LANES-1:0] loop_flag_o
);
  always_comb begin
    for (int n = 0; n < LANES; n++) begin
      if (!a2b_cen_i[n] && !a2b_len_i[n])
        assert_a2b_follow_R1: assert (a2b_held_o[n*BYTE_W +: BYTE_W] == a_i[n*BYTE_W +: BYTE_W]);
      if (b_drv_o[n])
        assert_b_carries_store_R4: assert (b_o[n*BYTE_W +: BYTE_W] == a2b_held_o[n*BYTE_W +: BYTE_W]);
      if (!b_drv_o[n])
        assert_b_idle_zero_R5: assert (b_o[n*BYTE_W +: BYTE_W] == '0);
      if (!a_drv_o[n])
        assert_a_idle_zero_R5: assert (a_o[n*BYTE_W +: BYTE_W] == '0);
      if (!b2a_cen_i[n] && !b2a_len_i[n])
        assert_b2a_follow_R7: assert (b2a_held_o[n*BYTE_W +: BYTE_W] == b_i[n*BYTE_W +: BYTE_W]);
      if (a_drv_o[n])
        assert_a_carries_store_R7: assert (a_o[n*BYTE_W +: BYTE_W] == b2a_held_o[n*BYTE_W +: BYTE_W]);
      if (loop_flag_o[n])
        assert_loop_drives_R10: assert (a_drv_o[n] && b_drv_o[n]);
    end
  end
endmodule

bind byte_latch_xcvr xcvr_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/byte_latch_xcvr_tb_top.sv
`timescale 1ns/1ps
module byte_latch_xcvr_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [15:0] a_i, b_i, b_o, a_o, a2b_held_o, b2a_held_o;
  logic [1:0]  a2b_cen_i, a2b_len_i, a2b_oen_i, b2a_cen_i, b2a_len_i, b2a_oen_i;
  logic [1:0]  b_drv_o, a_drv_o, loop_flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  byte_latch_xcvr dut_i (
    .a_i(a_i), .b_i(b_i),
    .a2b_cen_i(a2b_cen_i), .a2b_len_i(a2b_len_i), .a2b_oen_i(a2b_oen_i),
    .b2a_cen_i(b2a_cen_i), .b2a_len_i(b2a_len_i), .b2a_oen_i(b2a_oen_i),
    .b_o(b_o), .b_drv_o(b_drv_o), .a_o(a_o), .a_drv_o(a_drv_o),
    .a2b_held_o(a2b_held_o), .b2a_held_o(b2a_held_o), .loop_flag_o(loop_flag_o)
  );

  // control word per lane: {b2a_oen, b2a_len, b2a_cen, a2b_oen, a2b_len, a2b_cen}
  // vector: {a, b, ctl_lane0, ctl_lane1, exp_b, exp_bdrv, exp_a, exp_adrv}
  localparam int NVEC = 8;
  localparam logic [79:0] VEC [NVEC] = '{
    {16'h1234, 16'h0000, 6'b111000, 6'b111000, 16'h1234, 2'b11, 16'h0000, 2'b00},
    {16'h1234, 16'h0000, 6'b111010, 6'b111010, 16'h1234, 2'b11, 16'h0000, 2'b00},
    {16'h5678, 16'h9ABC, 6'b000111, 6'b000111, 16'h0000, 2'b00, 16'h9ABC, 2'b11},
    {16'h5678, 16'h9ABC, 6'b010001, 6'b010001, 16'h0000, 2'b00, 16'h9ABC, 2'b11},
    {16'hF00F, 16'h2222, 6'b111000, 6'b010001, 16'h000F, 2'b01, 16'h9A00, 2'b10},
    {16'hF00F, 16'h2222, 6'b111111, 6'b111111, 16'h0000, 2'b00, 16'h0000, 2'b00},
    {16'h4321, 16'h2222, 6'b110100, 6'b110100, 16'h0000, 2'b00, 16'h0000, 2'b00},
    {16'h4321, 16'h2222, 6'b110010, 6'b110010, 16'h4321, 2'b11, 16'h0000, 2'b00}
  };

  task automatic set_ctl(input logic [5:0] c0, input logic [5:0] c1);
    a2b_cen_i = {c1[0], c0[0]};
    a2b_len_i = {c1[1], c0[1]};
    a2b_oen_i = {c1[2], c0[2]};
    b2a_cen_i = {c1[3], c0[3]};
    b2a_len_i = {c1[4], c0[4]};
    b2a_oen_i = {c1[5], c0[5]};
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b,
                      input logic [5:0] c0, input logic [5:0] c1);
    @(posedge clk);
    a_i = a;
    b_i = b;
    set_ctl(c0, c1);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a_i = '0; b_i = '0;
    set_ctl(6'b111111, 6'b111111);

    // quiet start: all controls high, nothing driven (R5)
    step(16'h0000, 16'h0000, 6'b111111, 6'b111111);
    chk("R5 start b_drv", {14'd0, b_drv_o}, 16'd0);
    chk("R5 start a_drv", {14'd0, a_drv_o}, 16'd0);
    chk("R5 start b_o", b_o, 16'h0000);

    // vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][79:64], VEC[i][63:48], VEC[i][47:42], VEC[i][41:36]);
      chk("R4/R6/R8/R9 b_o", b_o, VEC[i][35:20]);
      chk("R4/R8 b_drv", {14'd0, b_drv_o}, {14'd0, VEC[i][19:18]});
      chk("R7/R8 a_o", a_o, VEC[i][17:2]);
      chk("R7/R8 a_drv", {14'd0, a_drv_o}, {14'd0, VEC[i][1:0]});
    end

    // R1: transparent store follows A, lane 1 held contrary (a2b closed)
    step(16'h4321, 16'h2222, 6'b111111, 6'b111111);
    step(16'h4321, 16'h2222, 6'b111100, 6'b000111);
    chk("R1 lane0 follows", {8'd0, a2b_held_o[7:0]}, 16'h0021);
    step(16'h77A5, 16'h2222, 6'b111100, 6'b000111);
    chk("R1 lane0 follows new", {8'd0, a2b_held_o[7:0]}, 16'h00A5);
    chk("R8 lane1 store untouched", {8'd0, a2b_held_o[15:8]}, 16'h0043);

    // R3: close gate, then change A: store keeps A5
    step(16'h77A5, 16'h2222, 6'b111110, 6'b000111);
    step(16'h1111, 16'h2222, 6'b111110, 6'b000111);
    chk("R3 frozen store", {8'd0, a2b_held_o[7:0]}, 16'h00A5);

    // R2: enable high, gate low, new data: store must hold
    step(16'h1111, 16'h2222, 6'b111111, 6'b111111);
    step(16'h1111, 16'h2222, 6'b111101, 6'b111111);
    step(16'h3C3C, 16'h2222, 6'b111101, 6'b111111);
    chk("R2 held under enable high", {8'd0, a2b_held_o[7:0]}, 16'h00A5);
    step(16'h3C3C, 16'h2222, 6'b111111, 6'b111111);
    step(16'h3C3C, 16'h2222, 6'b111010, 6'b111111);
    chk("R2/R4 drives held A5", b_o, 16'h00A5);

    // R7: B-to-A lane 1 alone, lane 0 contrary
    step(16'h3C3C, 16'h2222, 6'b111111, 6'b111111);
    step(16'h3C3C, 16'hBE00, 6'b111111, 6'b000111);
    chk("R7 lane1 a_o", a_o, 16'hBE00);
    chk("R7 lane1 a_drv", {14'd0, a_drv_o}, 16'd2);

    // R10: all six low on lane 1 only
    step(16'h5500, 16'hBE00, 6'b111111, 6'b111111);
    step(16'h5500, 16'hAA00, 6'b111111, 6'b000000);
    chk("R10 loop flag", {14'd0, loop_flag_o}, 16'd2);
    chk("R10 b side", b_o, 16'h5500);
    chk("R10 a side", a_o, 16'hAA00);
    step(16'h5500, 16'hAA00, 6'b111111, 6'b100000);
    chk("R10 flag clears", {14'd0, loop_flag_o}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule